// File: doc/BRIEF.md
# Cascaded Registered Address Counter

This block generates sequential memory addresses for a sampling data path. The counter is built from narrow counter slices joined in a chain. Two 8-bit slices form address bits 15:0, and a 1-bit slice on top forms bit 16, for a 17-bit address. Each slice is a count register followed by its own output holding register. A slice advances only when the carry from the slice below tells it to. Because the output register loads on the same rising edge that moves the counter, the address on the pins always shows the count value from one edge earlier.

A single active-high synchronous clear returns the whole chain to zero. A count-enable input gates advancement of every slice, while the output registers load on every edge. A terminal-count flag rises while the visible address sits at the all-ones value. Control logic uses it to detect that the memory has been swept and the address is about to wrap.

Top module: `addr_chain`

## Requirements
- R1: The address is 17 bits wide. Bits 7:0 and bits 15:8 each come from an 8-bit slice, and bit 16 comes from a 1-bit top slice.
- R2: When `clr` is high at a rising edge, the internal count, `addr_o` and `tc_o` are all zero after that edge. Clear takes priority over `cnt_en`.
- R3: When `cnt_en` is high and `clr` is low at a rising edge, the internal count increases by exactly one, modulo 2^17.
- R4: When `cnt_en` and `clr` are both low at a rising edge, the internal count holds its value. `addr_o` then settles to that held value one edge later and stays there.
- R5: When `clr` is low, `addr_o` loads the internal count on every rising edge. The visible address therefore equals the count value from the previous edge.
- R6: A slice advances only when every slice below it holds all ones and counting is enabled. For example, 0x000FF steps to 0x00100 and 0x0FFFF steps to 0x10000.
- R7: `tc_o` is 1 exactly in the cycles where `addr_o` equals 0x1FFFF, and 0 otherwise.
- R8: After the visible address 0x1FFFF, continued counting shows 0x00000 next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock, shared by the count and output registers |
| clr | input | 1 | Synchronous active-high clear of the count and output registers |
| cnt_en | input | 1 | Count enable, gating advancement of every slice |
| addr_o | output | 17 | Registered address, lagging the internal count by one edge |
| tc_o | output | 1 | Terminal count, high while `addr_o` is all ones |

## Verification
A change to `cnt_en` or `clr` reaches the internal count at the next rising edge. It reaches `addr_o` and `tc_o` only at the edge after that. A clear, by contrast, zeroes the pins at its own edge.

The bench keeps a model with the same two-step timing. The model count updates from the inputs present at an edge, and the model address takes the model count from before that edge. Both pins are compared 1 ns after every edge.

Directed runs count to the low-slice carry and to the full 17-bit wrap. At those points the expected address is written as the enabled-edge count minus one, so each check lands exactly on the edge where the lagged value appears.

// File: rtl/addr_chain_pkg.sv
package addr_chain_pkg;
   localparam int DEF_SLICE_W = 8;
   localparam int DEF_FULL_SLICES = 2;
   localparam int DEF_TOP_W = 1;

   function automatic int slice_width(input int idx, input int n_full,
                                      input int full_w, input int top_w);
      return (idx < n_full) ? full_w : top_w;
   endfunction
endpackage

// File: rtl/cnt_slice.sv
module cnt_slice #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         clr,
   input  logic         cen,
   output logic [W-1:0] cnt_o,
   output logic [W-1:0] q_o,
   output logic         rco_o
);
   if (W < 1) begin : g_bad_w
      $error("cnt_slice: W must be at least 1");
   end

   logic [W-1:0] cnt_q;
   logic [W-1:0] out_q;

   always_ff @(posedge clk) begin
      if (clr)      cnt_q <= '0;
      else if (cen) cnt_q <= cnt_q + W'(1);
   end

   always_ff @(posedge clk) begin
      if (clr) out_q <= '0;
      else     out_q <= cnt_q;
   end

   assign rco_o = cen & (&cnt_q);
   assign cnt_o = cnt_q;
   assign q_o   = out_q;

   // R6
   slice_wrap_chk: assert property (@(posedge clk) disable iff (clr)
      (cen && (&cnt_q)) |=> (cnt_q == '0));

   // R4
   slice_hold_chk: assert property (@(posedge clk) disable iff (clr)
      !cen |=> $stable(cnt_q));
endmodule

// File: rtl/addr_chain.sv
module addr_chain
   import addr_chain_pkg::*;
#(
   parameter int  SLICE_W     = DEF_SLICE_W,
   parameter int  FULL_SLICES = DEF_FULL_SLICES,
   parameter int  TOP_W       = DEF_TOP_W,
   parameter bit  TC_REG      = 1'b1,
   localparam int ADDR_W      = SLICE_W * FULL_SLICES + TOP_W,
   localparam int N_SLICES    = FULL_SLICES + 1
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              cnt_en,
   output logic [ADDR_W-1:0] addr_o,
   output logic              tc_o
);
   if (SLICE_W < 1 || FULL_SLICES < 1 || TOP_W < 1) begin : g_bad_cfg
      $error("addr_chain: slice widths and count must be at least 1");
   end

   logic [N_SLICES:0] carry;
   logic [ADDR_W-1:0] cnt_all;
   logic [ADDR_W-1:0] addr_all;

   assign carry[0] = cnt_en;

   for (genvar g = 0; g < N_SLICES; g++) begin : g_slice
      localparam int SW = slice_width(g, FULL_SLICES, SLICE_W, TOP_W);
      localparam int LO = g * SLICE_W;
      logic [SW-1:0] cnt_s;
      logic [SW-1:0] q_s;

      cnt_slice #(.W(SW)) u_slice (
         .clk   (clk),
         .clr   (clr),
         .cen   (carry[g]),
         .cnt_o (cnt_s),
         .q_o   (q_s),
         .rco_o (carry[g+1])
      );

      assign cnt_all[LO +: SW]  = cnt_s;
      assign addr_all[LO +: SW] = q_s;
   end

   assign addr_o = addr_all;

   if (TC_REG) begin : g_tc_reg
      logic tc_q;
      always_ff @(posedge clk) begin
         if (clr) tc_q <= 1'b0;
         else     tc_q <= &cnt_all;
      end
      assign tc_o = tc_q;

      // R7
      tc_align_chk: assert property (@(posedge clk) disable iff (clr)
         tc_o == (&addr_o));
   end else begin : g_tc_comb
      assign tc_o = &addr_all;
   end

   // R2
   clear_zero_chk: assert property (@(posedge clk)
      clr |=> (cnt_all == '0 && addr_o == '0 && !tc_o));

   // R3
   advance_chk: assert property (@(posedge clk) disable iff (clr)
      cnt_en |=> (cnt_all == $past(cnt_all) + ADDR_W'(1)));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (clr)
      !cnt_en |=> $stable(cnt_all));

   // R5
   lag_chk: assert property (@(posedge clk) disable iff (clr)
      !$past(clr) |-> (addr_o == $past(cnt_all)));
endmodule

// File: tb/tb_addr_chain.sv
module tb_addr_chain;
   localparam int AW = 17;
   localparam logic [AW-1:0] AMAX = 17'h1FFFF;

   logic          clk = 1'b0;
   logic          clr = 1'b1;
   logic          cnt_en = 1'b0;
   logic [AW-1:0] addr_o;
   logic          tc_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [AW-1:0] m_cnt = '0;
   logic [AW-1:0] m_addr = '0;
   logic          m_tc = 1'b0;

   always #2 clk = ~clk;

   addr_chain dut (
      .clk    (clk),
      .clr    (clr),
      .cnt_en (cnt_en),
      .addr_o (addr_o),
      .tc_o   (tc_o)
   );

   task automatic check(input bit ok, input string req,
                        input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%05h expected=%05h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [AW-1:0] nxt(input logic [AW-1:0] v);
      return v + AW'(1);
   endfunction

   // one clock: drive inputs at the falling edge, update the model and compare after the rising edge
   task automatic step(input logic en, input logic c);
      @(negedge clk);
      cnt_en = en;
      clr    = c;
      @(posedge clk);
      #1;
      if (c) begin
         m_cnt = '0; m_addr = '0; m_tc = 1'b0;
      end else begin
         m_addr = m_cnt;
         m_tc   = (m_cnt == AMAX);
         if (en) m_cnt = nxt(m_cnt);
      end
      check(addr_o === m_addr, "R5 address", addr_o, m_addr);
      check(tc_o === m_tc, "R7 terminal count", AW'(tc_o), AW'(m_tc));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [AW-1:0] held;
      void'($urandom(32'd4711));
      repeat (3) step(1'b0, 1'b1);
      // R2 reset state
      check(addr_o === '0, "R2 after clear", addr_o, '0);
      check(tc_o === 1'b0, "R2 tc after clear", AW'(tc_o), '0);

      // random phase
      for (int i = 0; i < 3000; i++) begin
         logic e, c;
         e = ($urandom % 4) != 0;
         c = ($urandom % 64) == 0;
         step(e, c);
      end

      // R6 low-slice carry: 257 enabled edges after a clear show 0x00100
      step(1'b0, 1'b1);
      for (int k = 0; k < 257; k++) step(1'b1, 1'b0);
      check(addr_o === 17'h00100, "R6 carry into slice 1", addr_o, 17'h00100);

      // R4 hold: count frozen, address settles then stays
      step(1'b0, 1'b0);
      held = addr_o;
      check(held === 17'h00101, "R4 settle", held, 17'h00101);
      for (int k = 0; k < 5; k++) begin
         step(1'b0, 1'b0);
         check(addr_o === held, "R4 hold", addr_o, held);
      end

      // R3 single advance after the hold
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      check(addr_o === 17'h00102, "R3 one increment", addr_o, 17'h00102);

      // R2 clear wins over enable
      step(1'b1, 1'b1);
      check(addr_o === '0, "R2 clear over enable", addr_o, '0);
      step(1'b0, 1'b0);
      check(addr_o === '0, "R2 count cleared", addr_o, '0);

      // full sweep: after k enabled edges from clear the address is k-1
      step(1'b0, 1'b1);
      for (int k = 1; k <= 32'h20001; k++) begin
         step(1'b1, 1'b0);
         if (k == 32'h10001) begin
            check(addr_o === 17'h10000, "R6 carry into top slice", addr_o, 17'h10000);
            check(addr_o[16] === 1'b1, "R1 bit 16 from top slice", AW'(addr_o[16]), AW'(1));
         end
         if (k == 32'h20000) begin
            check(addr_o === AMAX, "R7 last address", addr_o, AMAX);
            check(tc_o === 1'b1, "R7 tc at last address", AW'(tc_o), AW'(1));
         end
         if (k == 32'h1FFFF)
            check(tc_o === 1'b0, "R7 tc low before last", AW'(tc_o), '0);
      end
      check(addr_o === '0, "R8 wrap to zero", addr_o, '0);
      check(tc_o === 1'b0, "R8 tc drops after wrap", AW'(tc_o), '0);
      step(1'b1, 1'b0);
      check(addr_o === 17'h00001, "R3 count resumes", addr_o, 17'h00001);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule